// File: doc/BRIEF.md
# Bridge configuration read shim

The shim serves configuration reads aimed at a root bridge whose register backend answers only whole 64-bit reads of one aligned dword at a time. A host request carries a device/function number, a byte offset and an access size of 1, 2 or 4 bytes. For a legal request the shim sends the dword-aligned offset to the backend and takes the configuration dword from the upper half of the 64-bit answer. It then edits that dword at a small set of offsets so that the host sees a corrected and extended capability chain. Finally it shifts and masks the dword to the size that was asked for.

Most edits act on the dword just read. At offset 0xB0 the shim also needs the raw dword at 0x70, so it issues a second backend read before it answers. Three 32-bit entry registers, loaded through their own write port, supply the words of a synthesized resource-entry structure. Requests to another function, or beyond the first 2 KiB of configuration space, are refused without touching the backend.

Top module: `cfg_rd_shim`

## Requirements
- R1: A request with a nonzero `req_devfn` or with `req_off` of 2048 or more gets `rsp_data` = 0xFFFFFFFF and `rsp_notfound` = 1. It issues no backend request, and `rsp_valid` rises in the cycle after the request is accepted.
- R2: A legal request sends `req_off` with bits 1:0 cleared on `be_req_addr`, and uses `be_rsp_data[63:32]` as the raw dword. `be_req_valid` and `be_req_addr` stay unchanged until `be_req_ready` is seen.
- R3: At aligned offset 0x40 the dword is (raw AND 0xFFFF00FF) OR 0x00007000.
- R4: At aligned offset 0x70, if raw bits 29:25 are all zero, the value 2 is placed in that field (OR 0x04000000). Otherwise raw is returned unchanged.
- R5: At aligned offset 0xB0 the shim makes a second backend read at 0x70. The dword is (raw AND 0xC00000FF) OR 0x0003BC00 when bits 29:25 of that second raw dword are zero, and OR 0x0001BC00 otherwise.
- R6: Aligned offsets 0xB4, 0xB8, 0xBC, 0xC0 and 0xC4 return the constants 0x00000000, 0x000F0000, 0x00010014, 0x00000000 and 0x80FF0003, whatever the backend returns.
- R7: Aligned offsets 0xC8, 0xCC and 0xD0 return entry registers 0, 1 and 2.
- R8: `ent_we` with `ent_sel` 0, 1 or 2 loads `ent_wdata` into that entry register. `ent_sel` = 3 changes nothing. All three registers reset to zero.
- R9: The dword is shifted right by 8 × (`req_off` mod 4). For `req_size` = 1 it is then masked to 8 bits and for `req_size` = 2 to 16 bits. Any other `req_size` value, 4 included, is not masked.
- R10: Any other legal aligned offset returns the raw dword without change.
- R11: `req_ready` is high only when idle. It drops for the cycle after acceptance and stays low until the response. `rsp_valid` is a single-cycle pulse, after which `req_ready` is high again.
- R12: A legal request's `rsp_valid` rises in the cycle after the clock edge that samples its last `be_rsp_valid`, with `rsp_notfound` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Shim idle and able to accept |
| req_devfn | input | 8 | Device/function number |
| req_off | input | 12 | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Response data |
| rsp_notfound | output | 1 | Request refused |
| be_req_valid | output | 1 | Backend read request |
| be_req_ready | input | 1 | Backend accepts request |
| be_req_addr | output | 12 | Dword-aligned backend offset |
| be_rsp_valid | input | 1 | Backend read data present |
| be_rsp_data | input | 64 | Backend read data; config dword in 63:32 |
| ent_we | input | 1 | Entry register write strobe |
| ent_sel | input | 2 | Entry register index |
| ent_wdata | input | 32 | Entry register write data |

## Verification
A refused request must answer in the cycle straight after its acceptance edge. A legal one must answer in the cycle after the edge that samples the last backend response, which is the second response for offset 0xB0. The bench keeps a cycle counter and stamps both the acceptance edge and each backend response edge. It samples `rsp_valid` on the falling edge, so the counter value at which the response first shows must equal the stamp, with no margin. The backend responder inserts random delays before ready and before data. Because of this the bench sets the expected cycle from the responder's own stamp and never from a fixed count.

// File: rtl/cfgshim_pkg.sv
package cfgshim_pkg;

    localparam int CFG_DW = 32;
    localparam int N_ENT  = 3;

    localparam logic [31:0] A_CAP_NEXT  = 32'h0000_0040;
    localparam logic [31:0] A_EXP_CAP   = 32'h0000_0070;
    localparam logic [31:0] A_MSIX_HDR  = 32'h0000_00B0;
    localparam logic [31:0] A_TBL_OFF   = 32'h0000_00B4;
    localparam logic [31:0] A_PBA_OFF   = 32'h0000_00B8;
    localparam logic [31:0] A_EA_HDR    = 32'h0000_00BC;
    localparam logic [31:0] A_EA_DW2    = 32'h0000_00C0;
    localparam logic [31:0] A_EA_ENTHDR = 32'h0000_00C4;
    localparam logic [31:0] A_ENT0      = 32'h0000_00C8;
    localparam logic [31:0] A_ENT1      = 32'h0000_00CC;
    localparam logic [31:0] A_ENT2      = 32'h0000_00D0;

    localparam int PME_LO = 25;
    localparam int PME_HI = 29;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WT1,
        ST_RD2,
        ST_WT2,
        ST_RESP
    } shim_st_e;

endpackage

// File: rtl/cfgshim_entries.sv
module cfgshim_entries
    import cfgshim_pkg::*;
#(
    parameter int NUM   = N_ENT,
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  logic [CFG_DW-1:0]     wdata,
    output logic [NUM*CFG_DW-1:0] ent_flat
);

    for (genvar gi = 0; gi < NUM; gi++) begin : g_ent
        logic [CFG_DW-1:0] ent_d;
        logic [CFG_DW-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (32'(sel) == gi)) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_flat[gi*CFG_DW +: CFG_DW] = ent_q;

        // R8: a selected write lands in the register one edge later
        p_entry_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (we && (32'(sel) == gi)) |=> (ent_q == $past(wdata)));
    end

endmodule

// File: rtl/cfgshim_patch.sv
module cfgshim_patch
    import cfgshim_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0]        aoff,
    input  logic [CFG_DW-1:0]       raw,
    input  logic [CFG_DW-1:0]       raw_exp,
    input  logic [N_ENT*CFG_DW-1:0] ent_flat,
    output logic [CFG_DW-1:0]       dword
);

    logic [31:0] a32;
    logic        raw_pme_zero;
    logic        exp_pme_zero;

    assign a32          = 32'(aoff);
    assign raw_pme_zero = (raw[PME_HI:PME_LO] == '0);
    assign exp_pme_zero = (raw_exp[PME_HI:PME_LO] == '0);

    always_comb begin
        dword = raw;
        case (a32)
            A_CAP_NEXT:  dword = (raw & 32'hFFFF_00FF) | 32'h0000_7000;
            A_EXP_CAP:   dword = raw_pme_zero ? (raw | 32'h0400_0000) : raw;
            A_MSIX_HDR:  dword = (raw & 32'hC000_00FF) |
                                 (exp_pme_zero ? 32'h0003_BC00 : 32'h0001_BC00);
            A_TBL_OFF:   dword = 32'h0000_0000;
            A_PBA_OFF:   dword = 32'h000F_0000;
            A_EA_HDR:    dword = 32'h0001_0014;
            A_EA_DW2:    dword = 32'h0000_0000;
            A_EA_ENTHDR: dword = 32'h80FF_0003;
            A_ENT0:      dword = ent_flat[0*CFG_DW +: CFG_DW];
            A_ENT1:      dword = ent_flat[1*CFG_DW +: CFG_DW];
            A_ENT2:      dword = ent_flat[2*CFG_DW +: CFG_DW];
            default:     dword = raw;
        endcase
    end

endmodule

// File: rtl/cfgshim_align.sv
module cfgshim_align
    import cfgshim_pkg::*;
(
    input  logic [CFG_DW-1:0] dword,
    input  logic [1:0]        byte_sel,
    input  logic [2:0]        size,
    output logic [CFG_DW-1:0] data
);

    logic [CFG_DW-1:0] shifted;

    assign shifted = dword >> {byte_sel, 3'b000};

    always_comb begin
        case (size)
            3'd1:    data = shifted & 32'h0000_00FF;
            3'd2:    data = shifted & 32'h0000_FFFF;
            default: data = shifted;
        endcase
    end

endmodule

// File: rtl/cfg_rd_shim.sv
module cfg_rd_shim
    import cfgshim_pkg::*;
#(
    parameter int OFF_W     = 12,
    parameter int DEVFN_W   = 8,
    parameter int BE_W      = 64,
    parameter int OFF_LIMIT = 2048,
    parameter int SEL_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [2:0]         req_size,
    output logic               rsp_valid,
    output logic [CFG_DW-1:0]  rsp_data,
    output logic               rsp_notfound,
    output logic               be_req_valid,
    input  logic               be_req_ready,
    output logic [OFF_W-1:0]   be_req_addr,
    input  logic               be_rsp_valid,
    input  logic [BE_W-1:0]    be_rsp_data,
    input  logic               ent_we,
    input  logic [SEL_W-1:0]   ent_sel,
    input  logic [CFG_DW-1:0]  ent_wdata
);

    localparam int DATA_LO = BE_W - CFG_DW;

    typedef struct packed {
        shim_st_e          st;
        logic [OFF_W-1:0]  off;
        logic [2:0]        size;
        logic              bad;
        logic [CFG_DW-1:0] raw;
        logic [CFG_DW-1:0] raw_exp;
    } ctx_t;

    ctx_t ctx_d;
    ctx_t ctx_q;

    logic [OFF_W-1:0]        aoff_q;
    logic [N_ENT*CFG_DW-1:0] ent_flat;
    logic [CFG_DW-1:0]       patched;
    logic [CFG_DW-1:0]       sized;
    logic                    req_bad;

    assign aoff_q  = {ctx_q.off[OFF_W-1:2], 2'b00};
    assign req_bad = (req_devfn != '0) || (32'(req_off) >= OFF_LIMIT);

    always_comb begin
        ctx_d        = ctx_q;
        be_req_valid = 1'b0;
        be_req_addr  = aoff_q;
        req_ready    = (ctx_q.st == ST_IDLE);
        rsp_valid    = (ctx_q.st == ST_RESP);
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.off  = req_off;
                    ctx_d.size = req_size;
                    ctx_d.bad  = req_bad;
                    ctx_d.st   = req_bad ? ST_RESP : ST_RD1;
                end
            end
            ST_RD1: begin
                be_req_valid = 1'b1;
                if (be_req_ready) begin
                    ctx_d.st = ST_WT1;
                end
            end
            ST_WT1: begin
                if (be_rsp_valid) begin
                    ctx_d.raw = be_rsp_data[BE_W-1:DATA_LO];
                    ctx_d.st  = (32'(aoff_q) == A_MSIX_HDR) ? ST_RD2 : ST_RESP;
                end
            end
            ST_RD2: begin
                be_req_valid = 1'b1;
                be_req_addr  = OFF_W'(A_EXP_CAP);
                if (be_req_ready) begin
                    ctx_d.st = ST_WT2;
                end
            end
            ST_WT2: begin
                be_req_addr = OFF_W'(A_EXP_CAP);
                if (be_rsp_valid) begin
                    ctx_d.raw_exp = be_rsp_data[BE_W-1:DATA_LO];
                    ctx_d.st      = ST_RESP;
                end
            end
            ST_RESP: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, off: '0, size: '0, bad: 1'b0,
                       raw: '0, raw_exp: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    cfgshim_entries #(
        .NUM   (N_ENT),
        .SEL_W (SEL_W)
    ) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ent_we),
        .sel      (ent_sel),
        .wdata    (ent_wdata),
        .ent_flat (ent_flat)
    );

    cfgshim_patch #(
        .OFF_W (OFF_W)
    ) u_patch (
        .aoff     (aoff_q),
        .raw      (ctx_q.raw),
        .raw_exp  (ctx_q.raw_exp),
        .ent_flat (ent_flat),
        .dword    (patched)
    );

    cfgshim_align u_align (
        .dword    (patched),
        .byte_sel (ctx_q.off[1:0]),
        .size     (ctx_q.size),
        .data     (sized)
    );

    assign rsp_data     = ctx_q.bad ? '1 : sized;
    assign rsp_notfound = rsp_valid && ctx_q.bad;

    // R1: a request to a foreign function is answered on the next cycle, refused
    p_bad_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_devfn != '0))
        |=> (rsp_valid && rsp_notfound && (rsp_data == '1) && !be_req_valid));

    // R2: a pending backend request holds its address
    p_be_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req_valid && !be_req_ready) |=> (be_req_valid && $stable(be_req_addr)));

    // R11: no new acceptance while a request is outstanding
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: response is a single pulse followed by readiness
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: tb/tb_cfg_rd_shim.sv
`timescale 1ns/1ps
module tb_cfg_rd_shim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_off = '0;
    logic [2:0]  req_size = 3'd4;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_notfound;
    logic        be_req_valid;
    logic        be_req_ready = 1'b0;
    logic [11:0] be_req_addr;
    logic        be_rsp_valid = 1'b0;
    logic [63:0] be_rsp_data = '0;
    logic        ent_we = 1'b0;
    logic [1:0]  ent_sel = '0;
    logic [31:0] ent_wdata = '0;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          be_cnt = 0;
    int          last_rsp_cyc = 0;
    logic [11:0] addr_log [2];
    logic        pme_zero = 1'b1;
    logic [31:0] ent_m [3];
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_rd_shim dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_devfn    (req_devfn),
        .req_off      (req_off),
        .req_size     (req_size),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_notfound (rsp_notfound),
        .be_req_valid (be_req_valid),
        .be_req_ready (be_req_ready),
        .be_req_addr  (be_req_addr),
        .be_rsp_valid (be_rsp_valid),
        .be_rsp_data  (be_rsp_data),
        .ent_we       (ent_we),
        .ent_sel      (ent_sel),
        .ent_wdata    (ent_wdata)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic logic [31:0] be_model(input logic [11:0] a);
        logic [31:0] v;
        v = (32'(a) * 32'h0100_0193) ^ 32'hC0FF_EE11;
        if (a == 12'h070) begin
            if (pme_zero) v = v & ~32'h3E00_0000;
            else          v = v | 32'h0800_0000;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_dword(input logic [11:0] a);
        logic [31:0] r;
        logic [31:0] r70;
        r   = be_model(a);
        r70 = be_model(12'h070);
        case (a)
            12'h040: return (r & 32'hFFFF_00FF) | 32'h0000_7000;
            12'h070: return (r[29:25] == 5'd0) ? (r | (32'd2 << 25)) : r;
            12'h0B0: return (r & 32'hC000_00FF) |
                            ((r70[29:25] == 5'd0) ? 32'h0003_BC00 : 32'h0001_BC00);
            12'h0B4: return 32'h0;
            12'h0B8: return 32'h000F_0000;
            12'h0BC: return 32'h0001_0014;
            12'h0C0: return 32'h0;
            12'h0C4: return 32'h80FF_0003;
            12'h0C8: return ent_m[0];
            12'h0CC: return ent_m[1];
            12'h0D0: return ent_m[2];
            default: return r;
        endcase
    endfunction

    function automatic logic [31:0] size_it(input logic [31:0] d, input logic [1:0] lane,
                                            input logic [2:0] sz);
        logic [31:0] s;
        s = d >> (8 * lane);
        if (sz == 3'd1) s = s & 32'hFF;
        else if (sz == 3'd2) s = s & 32'hFFFF;
        return s;
    endfunction

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'h040: return "R3";
            12'h070: return "R4";
            12'h0B0: return "R5";
            12'h0B4, 12'h0B8, 12'h0BC, 12'h0C0, 12'h0C4: return "R6";
            12'h0C8, 12'h0CC, 12'h0D0: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", rq, what, act, exp);
        end
    endtask

    // backend responder with random latencies
    initial forever begin
        @(negedge clk);
        if (be_req_valid && rst_n) begin
            repeat ($urandom % 3) @(negedge clk);
            be_req_ready = 1'b1;
            if (be_cnt < 2) addr_log[be_cnt] = be_req_addr;
            be_cnt++;
            @(negedge clk);
            be_req_ready = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
            be_rsp_data  = {be_model(addr_log[(be_cnt - 1) % 2]), $urandom};
            be_rsp_valid = 1'b1;
            @(posedge clk);
            #1 last_rsp_cyc = cyc;
            @(negedge clk);
            be_rsp_valid = 1'b0;
        end
    end

    task automatic wr_entry(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        ent_we = 1'b1;
        ent_sel = sel;
        ent_wdata = d;
        @(negedge clk);
        ent_we = 1'b0;
        if (sel != 2'd3) ent_m[sel] = d;
    endtask

    task automatic rd(input logic [7:0] fn, input logic [11:0] off, input logic [2:0] sz);
        int          acc;
        int          k;
        bit          bad;
        bit          busy_ok;
        logic [11:0] a;
        logic [31:0] exp;
        string       rq;
        a   = {off[11:2], 2'b00};
        bad = (fn != 0) || (off >= 12'd2048);
        @(negedge clk);
        chk("R11", "ready when idle", 32'(req_ready), 32'd1);
        be_cnt    = 0;
        req_valid = 1'b1;
        req_devfn = fn;
        req_off   = off;
        req_size  = sz;
        @(posedge clk);
        #1 acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && k < 100) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            k++;
        end
        chk("R11", "ready low while busy", 32'(busy_ok), 32'd1);
        if (bad) begin
            chk("R1", "latency", 32'(cyc), 32'(acc));
            chk("R1", "data", rsp_data, 32'hFFFF_FFFF);
            chk("R1", "notfound", 32'(rsp_notfound), 32'd1);
            chk("R1", "backend reads", 32'(be_cnt), 32'd0);
        end else begin
            rq  = req_of(a);
            exp = size_it(exp_dword(a), off[1:0], sz);
            chk(rq, "data", rsp_data, exp);
            chk("R12", "latency", 32'(cyc), 32'(last_rsp_cyc));
            chk("R12", "notfound", 32'(rsp_notfound), 32'd0);
            chk("R2", "first addr", 32'(addr_log[0]), 32'(a));
            if (a == 12'h0B0) begin
                chk("R5", "reads", 32'(be_cnt), 32'd2);
                chk("R5", "second addr", 32'(addr_log[1]), 32'h70);
            end else begin
                chk("R2", "reads", 32'(be_cnt), 32'd1);
            end
        end
        @(negedge clk);
        chk("R11", "single pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] spec [12];
        int unsigned s;
        s = $urandom(32'd4242);
        spec = '{12'h040, 12'h070, 12'h0B0, 12'h0B4, 12'h0B8, 12'h0BC,
                 12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0, 12'h044};
        for (int i = 0; i < 3; i++) ent_m[i] = '0;
        repeat (3) @(negedge clk);
        chk("R11", "reset ready", 32'(req_ready), 32'd1);
        chk("R11", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R2", "reset be_req_valid", 32'(be_req_valid), 32'd0);
        rst_n = 1'b1;
        // R8: entries reset to zero
        rd(8'd0, 12'h0C8, 3'd4);
        rd(8'd0, 12'h0CC, 3'd4);
        rd(8'd0, 12'h0D0, 3'd4);
        wr_entry(2'd0, 32'h8765_0002);
        wr_entry(2'd1, 32'h000F_FFFC);
        wr_entry(2'd2, 32'h0000_0012);
        // R8: index 3 writes nothing
        wr_entry(2'd3, 32'hDEAD_BEEF);
        rd(8'd0, 12'h0C8, 3'd4);
        rd(8'd0, 12'h0CC, 3'd4);
        rd(8'd0, 12'h0D0, 3'd4);
        // R1 boundaries
        rd(8'd1, 12'h040, 3'd4);
        rd(8'd0, 12'd2048, 3'd4);
        rd(8'd0, 12'd2047, 3'd1);
        rd(8'd0, 12'd2044, 3'd4);
        // R4, R5 in both PME modes; R9 lanes and sizes
        for (int m = 0; m < 2; m++) begin
            pme_zero = (m == 0);
            foreach (spec[j]) begin
                for (int ln = 0; ln < 4; ln++) begin
                    rd(8'd0, spec[j] | 12'(ln), 3'd1);
                end
                rd(8'd0, spec[j] | 12'd2, 3'd2);
                rd(8'd0, spec[j], 3'd4);
            end
        end
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] o;
            logic [7:0]  f;
            logic [2:0]  z;
            if ((i % 60) == 0) pme_zero = ~pme_zero;
            if ($urandom % 10 == 0) wr_entry(2'($urandom % 4), $urandom);
            o = ($urandom % 2 == 0) ? (spec[$urandom % 12] | 12'($urandom % 4))
                                    : 12'($urandom % 2400);
            f = ($urandom % 10 == 0) ? 8'(1 + $urandom % 255) : 8'd0;
            case ($urandom % 3)
                0: z = 3'd1;
                1: z = 3'd2;
                default: z = 3'd4;
            endcase
            rd(f, o, z);
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule